// File: doc/BRIEF.md
# Single-Instruction Repeat Controller

This block lets a processor core run the instruction that follows a repeat-setup instruction a programmed number of times. A count is captured on a load strobe, taken either from a data operand or from an immediate field of the setup instruction. The value written is one less than the desired number of executions, so an 8-bit count covers from 1 to 256 executions.

While a repeat is in progress the controller asks the fetch stage to keep reissuing the same instruction word without advancing the program counter, and it tells the execute stage which pass is the final one. The execute stage reports each finished pass with a one-cycle completion pulse. The count is decremented on each pulse, and the repeat ends after the pass taken with a count of zero. The instruction that carries the load is not itself counted: the first pass is the instruction that follows it.

Top module: `rpt_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all three output flags read 0 after that edge, and the stored count is discarded.
- R2: On a load, `rpt_src` = 0 selects `rpt_mem_cnt` and `rpt_src` = 1 selects `rpt_imm_cnt` as the count; the other input has no effect.
- R3: After a load of value N, exactly N+1 `instr_done` pulses are accepted while `rpt_active` is 1, and `rpt_active` falls in the cycle after the (N+1)th pulse.
- R4: `hold_fetch` is 1 exactly when a repeat is active and at least one more pass remains after the current one; it is 1 in the cycle after a load of a nonzero value.
- R5: `rpt_last` is 1 exactly while a repeat is active and the current pass is the final one; it rises in the cycle after the Nth pulse, and `hold_fetch` and `rpt_last` are never 1 together.
- R6: A load of 0 gives exactly one pass: `rpt_last` is 1 from the cycle after the load and `hold_fetch` never rises.
- R7: An `instr_done` pulse in the same cycle as the load strobe is not counted as a pass.
- R8: An `instr_done` pulse while no repeat is active has no effect: all flags stay 0.
- R9: A load while a repeat is active restarts the repeat with the new count.
- R10: A load of 255 gives exactly 256 passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rpt_load | input | 1 | Load strobe from the repeat-setup instruction |
| rpt_src | input | 1 | Count source: 0 data operand, 1 immediate field |
| rpt_mem_cnt | input | 8 | Count taken from a data operand |
| rpt_imm_cnt | input | 8 | Count taken from the immediate field |
| instr_done | input | 1 | One-cycle pulse when a pass of the repeated instruction finishes |
| hold_fetch | output | 1 | Keep the current instruction word; do not advance the program counter |
| rpt_active | output | 1 | A repeat is in progress |
| rpt_last | output | 1 | The current pass is the final one |

## Verification
The load strobe and a completion pulse can arrive in the same cycle, because the setup instruction finishes as its count is written. The bench drives both together and then counts the passes that follow, expecting exactly N+1, so a design that counted the setup instruction would end one pass early. A reload during a running repeat is provoked the same way, with the new count judged by the number of further passes and the flag values before each one.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int unsigned RPT_CNT_W = 8;

  typedef enum logic {
    SRC_MEM = 1'b0,
    SRC_IMM = 1'b1
  } rpt_src_e;
endpackage

// File: rtl/rpt_src_mux.sv
module rpt_src_mux #(
  parameter int unsigned W = rpt_pkg::RPT_CNT_W
) (
  input  rpt_pkg::rpt_src_e sel,
  input  logic [W-1:0]      mem_val,
  input  logic [W-1:0]      imm_val,
  output logic [W-1:0]      cnt_val
);
  always_comb begin
    unique case (sel)
      rpt_pkg::SRC_IMM: cnt_val = imm_val;
      default:          cnt_val = mem_val;
    endcase
  end
endmodule

// File: rtl/rpt_counter.sv
module rpt_counter #(
  parameter int unsigned W = rpt_pkg::RPT_CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         done,
  output logic [W-1:0] nxt_cnt,
  output logic         nxt_active
);
  logic [W-1:0] cnt_q;
  logic         active_q;

  // load has priority: the setup instruction's own completion is not a pass
  always_comb begin
    nxt_cnt    = cnt_q;
    nxt_active = active_q;
    if (load) begin
      nxt_cnt    = load_val;
      nxt_active = 1'b1;
    end else if (done && active_q) begin
      if (cnt_q == '0) nxt_active = 1'b0;
      else             nxt_cnt    = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= nxt_cnt;
      active_q <= nxt_active;
    end
  end
endmodule

// File: rtl/rpt_flag_gen.sv
module rpt_flag_gen #(
  parameter int unsigned W = rpt_pkg::RPT_CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nxt_cnt,
  input  logic         nxt_active,
  output logic         hold_q,
  output logic         active_q,
  output logic         last_q
);
  logic at_zero;
  assign at_zero = (nxt_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= 1'b0;
      active_q <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      hold_q   <= nxt_active && !at_zero;
      active_q <= nxt_active;
      last_q   <= nxt_active && at_zero;
    end
  end
endmodule

// File: rtl/rpt_ctrl.sv
module rpt_ctrl #(
  parameter int unsigned CNT_W = rpt_pkg::RPT_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rpt_load,
  input  logic             rpt_src,
  input  logic [CNT_W-1:0] rpt_mem_cnt,
  input  logic [CNT_W-1:0] rpt_imm_cnt,
  input  logic             instr_done,
  output logic             hold_fetch,
  output logic             rpt_active,
  output logic             rpt_last
);
  logic [CNT_W-1:0] sel_cnt;
  logic [CNT_W-1:0] nxt_cnt;
  logic             nxt_active;

  rpt_src_mux #(.W(CNT_W)) u_mux (
    .sel     (rpt_pkg::rpt_src_e'(rpt_src)),
    .mem_val (rpt_mem_cnt),
    .imm_val (rpt_imm_cnt),
    .cnt_val (sel_cnt)
  );

  rpt_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load       (rpt_load),
    .load_val   (sel_cnt),
    .done       (instr_done),
    .nxt_cnt    (nxt_cnt),
    .nxt_active (nxt_active)
  );

  rpt_flag_gen #(.W(CNT_W)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .nxt_cnt    (nxt_cnt),
    .nxt_active (nxt_active),
    .hold_q     (hold_fetch),
    .active_q   (rpt_active),
    .last_q     (rpt_last)
  );
endmodule

// File: rtl/rpt_ctrl_chk.sv
module rpt_ctrl_chk #(
  parameter int unsigned CNT_W = rpt_pkg::RPT_CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             rpt_load,
  input logic             rpt_src,
  input logic [CNT_W-1:0] rpt_mem_cnt,
  input logic [CNT_W-1:0] rpt_imm_cnt,
  input logic             instr_done,
  input logic             hold_fetch,
  input logic             rpt_active,
  input logic             rpt_last
);
  logic [CNT_W-1:0] chosen;
  assign chosen = rpt_src ? rpt_imm_cnt : rpt_mem_cnt;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!hold_fetch && !rpt_active && !rpt_last));

  assert_hold_needs_active_R4: assert property (@(posedge clk) disable iff (rst)
    hold_fetch |-> rpt_active);

  assert_load_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (rpt_load && chosen != '0) |=> (hold_fetch && rpt_active));

  assert_last_needs_active_R5: assert property (@(posedge clk) disable iff (rst)
    rpt_last |-> rpt_active);

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hold_fetch, rpt_last}));

  assert_load_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rpt_load && chosen == '0) |=> (rpt_last && !hold_fetch));

  assert_final_pass_ends_R3: assert property (@(posedge clk) disable iff (rst)
    (!rpt_load && instr_done && rpt_last) |=> !rpt_active);

  assert_mid_pass_continues_R3: assert property (@(posedge clk) disable iff (rst)
    (!rpt_load && instr_done && hold_fetch) |=> rpt_active);

  assert_idle_done_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!rpt_load && !rpt_active && instr_done) |=> !rpt_active);
endmodule

bind rpt_ctrl rpt_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rpt_load    (rpt_load),
  .rpt_src     (rpt_src),
  .rpt_mem_cnt (rpt_mem_cnt),
  .rpt_imm_cnt (rpt_imm_cnt),
  .instr_done  (instr_done),
  .hold_fetch  (hold_fetch),
  .rpt_active  (rpt_active),
  .rpt_last    (rpt_last)
);

// File: tb/sim_rpt_ctrl.sv
`timescale 1ns/1ps
module sim_rpt_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rpt_load = 1'b0;
  logic       rpt_src = 1'b0;
  logic [7:0] rpt_mem_cnt = '0;
  logic [7:0] rpt_imm_cnt = '0;
  logic       instr_done = 1'b0;
  logic       hold_fetch, rpt_active, rpt_last;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rpt_ctrl u0 (
    .clk(clk), .rst(rst), .rpt_load(rpt_load), .rpt_src(rpt_src),
    .rpt_mem_cnt(rpt_mem_cnt), .rpt_imm_cnt(rpt_imm_cnt),
    .instr_done(instr_done), .hold_fetch(hold_fetch),
    .rpt_active(rpt_active), .rpt_last(rpt_last)
  );

  // {src, mem count, imm count, expected passes}
  localparam logic [25:0] VEC [0:7] = '{
    {1'b0, 8'd3,   8'd9,   9'd4},
    {1'b1, 8'd3,   8'd9,   9'd10},
    {1'b0, 8'd0,   8'd7,   9'd1},
    {1'b1, 8'd5,   8'd0,   9'd1},
    {1'b0, 8'd255, 8'd1,   9'd256},
    {1'b1, 8'd0,   8'd1,   9'd2},
    {1'b0, 8'd1,   8'd200, 9'd2},
    {1'b1, 8'd17,  8'd16,  9'd17}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic src, input logic [7:0] m, input logic [7:0] i,
                         input logic with_done);
    @(negedge clk);
    rpt_load = 1'b1; rpt_src = src; rpt_mem_cnt = m; rpt_imm_cnt = i;
    instr_done = with_done;
    @(negedge clk);
    rpt_load = 1'b0; instr_done = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
  endtask

  // walk passes, checking flags before each; returns passes taken
  task automatic run_passes(input string req, input int exp, input int limit, output int n);
    n = 0;
    while (rpt_active && n < limit) begin
      checks++;
      if (hold_fetch != (exp - 1 - n > 0) || rpt_last != (exp - 1 - n == 0)) begin
        fails++;
        $display("FAIL %s pass %0d hold=%0b last=%0b expected hold=%0b last=%0b",
                 req, n, hold_fetch, rpt_last, (exp - 1 - n > 0), (exp - 1 - n == 0));
      end
      pulse_done();
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hold", hold_fetch, 0);
    check("R1 active", rpt_active, 0);
    check("R1 last", rpt_last, 0);
    rst = 1'b0;

    // R2 R3 R4 R5 R6 R10 vector table
    for (int k = 0; k < 8; k++) begin
      logic [25:0] v;
      v = VEC[k];
      do_load(v[25], v[24:17], v[16:9], 1'b0);
      check("R2 active after load", rpt_active, 1);
      run_passes("R3/R4/R5 flags", int'(v[8:0]), 300, n);
      check("R3 R10 pass count", n, int'(v[8:0]));
      check("R3 ends idle", rpt_active, 0);
    end

    // R6 zero load: hold never rises, one pass
    do_load(1'b1, 8'd9, 8'd0, 1'b0);
    check("R6 hold after zero load", hold_fetch, 0);
    check("R6 last after zero load", rpt_last, 1);
    pulse_done();
    check("R6 one pass", rpt_active, 0);

    // R7 done together with load is not a pass
    do_load(1'b0, 8'd2, 8'd0, 1'b1);
    check("R7 hold", hold_fetch, 1);
    run_passes("R7 flags", 3, 10, n);
    check("R7 pass count", n, 3);

    // R8 done while idle
    pulse_done();
    check("R8 active", rpt_active, 0);
    check("R8 hold", hold_fetch, 0);
    check("R8 last", rpt_last, 0);

    // R9 reload mid-repeat
    do_load(1'b1, 8'd0, 8'd5, 1'b0);
    pulse_done();
    pulse_done();
    check("R9 still active", rpt_active, 1);
    do_load(1'b0, 8'd1, 8'd0, 1'b0);
    run_passes("R9 flags", 2, 10, n);
    check("R9 pass count", n, 2);

    // R1 reset mid-repeat
    do_load(1'b0, 8'd40, 8'd0, 1'b0);
    pulse_done();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid hold", hold_fetch, 0);
    check("R1 mid active", rpt_active, 0);
    check("R1 mid last", rpt_last, 0);
    pulse_done();
    check("R1 count discarded", rpt_active, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule